// File: doc/BRIEF.md
# GPE and PCI Hotplug Register Block

This block holds the registers that report PCI slot insertions and removals to system software. A byte-wide port reaches a 16-bit event status register and a 16-bit event enable register, one byte at a time. A 32-bit port reaches two slot bitmaps, one for inserted slots and one for removed slots, and an eject register.

A hotplug event interface reports a slot number and whether the card was inserted or removed. The block records the event in the bitmaps and raises the hotplug bit of the event status register. `gpe_pending` is high while that status bit and its enable bit are both set. Software acknowledges the event by clearing the status bit with a write-one. A write to the eject register names a slot through its lowest set bit. The block answers with a one-cycle eject request carrying that slot number.

The asynchronous reset is released through a two-stage synchronizer. Internal state therefore leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `gpe_hotplug_regs`

## Requirements
- R1: Byte port offsets 0 and 1 read the low and high byte of the event status register. Offsets 2 and 3 read the low and high byte of the event enable register. A read returns the addressed byte combinationally from the current register contents.
- R2: A byte write to offset 0 or 1 clears every bit of the addressed status byte that is written as 1. It leaves the other bits of that byte, and the other byte, unchanged.
- R3: A byte write to offset 2 or 3 replaces the addressed enable byte with the written value. The other enable byte is unchanged.
- R4: Byte port offsets 4 to 7 read as zero, and writes to them change neither register.
- R5: `gpe_pending` is high exactly when status bit 1 (the hotplug bit, mask 0x0002) and enable bit 1 are both set.
- R6: On the 32-bit port, offset 0 holds the inserted bitmap and offset 4 the removed bitmap. Both are read back and fully rewritten by software. Offset 8 (eject) reads as zero. Every other offset reads as zero and ignores writes.
- R7: An event with `ev_valid` and `ev_hotadded` high clears both bitmaps. It then sets bit `ev_slot` of the inserted bitmap when `ev_insert` is 1, or of the removed bitmap when `ev_insert` is 0, and sets status bit 1. The result is visible after the next clock edge. In the same cycle it takes precedence over a software bitmap write and over a write-one clearing status bit 1.
- R8: An event with `ev_hotadded` low changes no state.
- R9: A write of a nonzero value to offset 8 produces, one clock edge later, a single-cycle `eject_valid` pulse. `eject_slot` then holds the index of the lowest set bit of the written value. Back-to-back writes give back-to-back pulses.
- R10: A write of zero to offset 8 produces no eject pulse.
- R11: Reset clears both event registers, both bitmaps and `eject_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpe_wr_en | input | 1 | Byte port write strobe |
| gpe_addr | input | 3 | Byte port offset |
| gpe_wdata | input | 8 | Byte port write data |
| gpe_rdata | output | 8 | Byte port read data |
| hp_wr_en | input | 1 | Slot port write strobe |
| hp_addr | input | 4 | Slot port byte offset |
| hp_wdata | input | 32 | Slot port write data |
| hp_rdata | output | 32 | Slot port read data |
| ev_valid | input | 1 | Hotplug event strobe |
| ev_hotadded | input | 1 | Event belongs to a hot-added card (0: present at boot, ignored) |
| ev_insert | input | 1 | 1 for insertion, 0 for removal |
| ev_slot | input | 5 | Slot number of the event |
| gpe_pending | output | 1 | Hotplug status and enable both set |
| eject_valid | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot named by the eject request |

## Verification
The assertions assume that each input is stable across a clock edge and holds a defined value whenever reset is released. They do not assume that byte writes, slot writes and events are mutually exclusive. Instead, each property names the conditions under which it applies: the write-one check holds only when no event sets the hotplug bit in the same cycle, and the no-effect checks hold only when no other source writes. The bench drives every input at the falling edge. It first exercises each behaviour in directed phases, then mixes simultaneous writes and events at random, so every precedence case is reached.

// File: rtl/gph_pkg.sv
package gph_pkg;

  localparam int HP_AW = 4;

  typedef enum logic [1:0] {
    HSEL_INS   = 2'd0,
    HSEL_REM   = 2'd1,
    HSEL_EJECT = 2'd2,
    HSEL_NONE  = 2'd3
  } hp_sel_e;

  function automatic hp_sel_e hp_decode(input logic [HP_AW-1:0] a);
    hp_sel_e s;
    case (a)
      4'h0:    s = HSEL_INS;
      4'h4:    s = HSEL_REM;
      4'h8:    s = HSEL_EJECT;
      default: s = HSEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gph_gpe_bank.sv
module gph_gpe_bank #(
  parameter int GPE_W  = 16,
  parameter int AW     = 3,
  parameter int HP_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  input  logic             hp_set,
  output logic [7:0]       rdata,
  output logic [GPE_W-1:0] stat_q,
  output logic [GPE_W-1:0] en_q
);

  localparam int NB = GPE_W / 8;
  localparam int LW = $clog2(NB);
  localparam int RW = AW - LW;

  logic [LW-1:0]    lane;
  logic [RW-1:0]    region;
  logic             is_stat;
  logic             is_en;
  logic [GPE_W-1:0] stat_w1c;
  logic [GPE_W-1:0] en_rep;
  logic [GPE_W-1:0] stat_d;
  logic [GPE_W-1:0] en_d;
  logic             stat_ce;
  logic             en_ce;

  assign lane    = addr[LW-1:0];
  assign region  = addr[AW-1:LW];
  assign is_stat = (region == RW'(0));
  assign is_en   = (region == RW'(1));

  generate
    for (genvar b = 0; b < NB; b++) begin : g_lane
      logic hit;
      assign hit = wr_en && (lane == LW'(b));
      assign stat_w1c[b*8 +: 8] = (hit && is_stat) ? (stat_q[b*8 +: 8] & ~wdata)
                                                   : stat_q[b*8 +: 8];
      assign en_rep[b*8 +: 8]   = (hit && is_en) ? wdata : en_q[b*8 +: 8];
    end
  endgenerate

  always_comb begin
    stat_d = stat_w1c;
    if (hp_set) stat_d[HP_BIT] = 1'b1;
    stat_ce = (wr_en && is_stat) || hp_set;
    en_d    = en_rep;
    en_ce   = wr_en && is_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (stat_ce) stat_q <= stat_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_stat)    rdata = stat_q[{lane, 3'b000} +: 8];
    else if (is_en) rdata = en_q[{lane, 3'b000} +: 8];
  end

  AST_HP_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    hp_set |=> stat_q[HP_BIT]); // R7

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_stat && !hp_set && lane == LW'(0)) |=>
      ((stat_q[7:0] & $past(wdata)) == 8'h00) &&
      (stat_q[GPE_W-1:8] == $past(stat_q[GPE_W-1:8]))); // R2

  AST_EN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_en && lane == LW'(0)) |=>
      (en_q[7:0] == $past(wdata)) &&
      (en_q[GPE_W-1:8] == $past(en_q[GPE_W-1:8]))); // R3

  AST_UNK_NOEFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_stat && !is_en && !hp_set) |=>
      ($stable(stat_q) && $stable(en_q))); // R4

endmodule

// File: rtl/gph_slot_maps.sv
module gph_slot_maps #(
  parameter int SLOT_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ins,
  input  logic                       wr_rem,
  input  logic [(1 << SLOT_W)-1:0]   wdata,
  input  logic                       ev_take,
  input  logic                       ev_insert,
  input  logic [SLOT_W-1:0]          ev_slot,
  output logic [(1 << SLOT_W)-1:0]   ins_q,
  output logic [(1 << SLOT_W)-1:0]   rem_q
);

  localparam int NS = 1 << SLOT_W;

  logic [NS-1:0] slot_hot;
  logic [NS-1:0] ins_d;
  logic [NS-1:0] rem_d;
  logic          map_ce;

  generate
    for (genvar i = 0; i < NS; i++) begin : g_hot
      assign slot_hot[i] = (ev_slot == SLOT_W'(i));
    end
  endgenerate

  always_comb begin
    ins_d = ins_q;
    rem_d = rem_q;
    if (wr_ins) ins_d = wdata;
    if (wr_rem) rem_d = wdata;
    if (ev_take) begin
      ins_d = ev_insert ? slot_hot : '0;
      rem_d = ev_insert ? '0 : slot_hot;
    end
    map_ce = wr_ins || wr_rem || ev_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (map_ce) begin
      ins_q <= ins_d;
      rem_q <= rem_d;
    end
  end

  AST_EV_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && ev_insert) |=>
      ($countones(ins_q) == 1) && (rem_q == '0) &&
      (ins_q[$past(ev_slot)] == 1'b1)); // R7

  AST_EV_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && !ev_insert) |=>
      ($countones(rem_q) == 1) && (ins_q == '0) &&
      (rem_q[$past(ev_slot)] == 1'b1)); // R7

  AST_MAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_take && !wr_ins && !wr_rem) |=> ($stable(ins_q) && $stable(rem_q))); // R8

endmodule

// File: rtl/gph_eject.sv
module gph_eject #(
  parameter int SLOT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [(1 << SLOT_W)-1:0] wdata,
  output logic                     ej_valid_q,
  output logic [SLOT_W-1:0]        ej_slot_q
);

  localparam int NS = 1 << SLOT_W;

  logic [SLOT_W-1:0] pick;
  logic              any_set;
  logic              valid_d;

  always_comb begin
    pick = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (wdata[i]) pick = SLOT_W'(i);
    end
    any_set = |wdata;
    valid_d = wr && any_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ej_valid_q <= 1'b0;
      ej_slot_q  <= '0;
    end else begin
      ej_valid_q <= valid_d;
      if (valid_d) ej_slot_q <= pick;
    end
  end

  AST_EJ_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == '0) |=> !ej_valid_q); // R10

  AST_EJ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata != '0) |=>
      ej_valid_q &&
      ((($past(wdata) >> ej_slot_q) & NS'(1)) == NS'(1)) &&
      (($past(wdata) & ((NS'(1) << ej_slot_q) - NS'(1))) == '0)); // R9

  AST_EJ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !ej_valid_q); // R9

endmodule

// File: rtl/gpe_hotplug_regs.sv
module gpe_hotplug_regs
  import gph_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int GPE_W  = 16,
  parameter int GPE_AW = 3,
  parameter int HP_BIT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gpe_wr_en,
  input  logic [GPE_AW-1:0]        gpe_addr,
  input  logic [7:0]               gpe_wdata,
  output logic [7:0]               gpe_rdata,
  input  logic                     hp_wr_en,
  input  logic [HP_AW-1:0]         hp_addr,
  input  logic [(1 << SLOT_W)-1:0] hp_wdata,
  output logic [(1 << SLOT_W)-1:0] hp_rdata,
  input  logic                     ev_valid,
  input  logic                     ev_hotadded,
  input  logic                     ev_insert,
  input  logic [SLOT_W-1:0]        ev_slot,
  output logic                     gpe_pending,
  output logic                     eject_valid,
  output logic [SLOT_W-1:0]        eject_slot
);

  localparam int NS = 1 << SLOT_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  hp_sel_e          hsel;
  logic             ev_take;
  logic [GPE_W-1:0] stat_q;
  logic [GPE_W-1:0] en_q;
  logic [NS-1:0]    ins_q;
  logic [NS-1:0]    rem_q;
  logic             wr_ins;
  logic             wr_rem;
  logic             wr_eject;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hsel     = hp_decode(hp_addr);
  assign ev_take  = ev_valid && ev_hotadded;
  assign wr_ins   = hp_wr_en && (hsel == HSEL_INS);
  assign wr_rem   = hp_wr_en && (hsel == HSEL_REM);
  assign wr_eject = hp_wr_en && (hsel == HSEL_EJECT);

  gph_gpe_bank #(
    .GPE_W  (GPE_W),
    .AW     (GPE_AW),
    .HP_BIT (HP_BIT)
  ) u_gpe (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (gpe_wr_en),
    .addr   (gpe_addr),
    .wdata  (gpe_wdata),
    .hp_set (ev_take),
    .rdata  (gpe_rdata),
    .stat_q (stat_q),
    .en_q   (en_q)
  );

  gph_slot_maps #(
    .SLOT_W (SLOT_W)
  ) u_maps (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_ins    (wr_ins),
    .wr_rem    (wr_rem),
    .wdata     (hp_wdata),
    .ev_take   (ev_take),
    .ev_insert (ev_insert),
    .ev_slot   (ev_slot),
    .ins_q     (ins_q),
    .rem_q     (rem_q)
  );

  gph_eject #(
    .SLOT_W (SLOT_W)
  ) u_eject (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr         (wr_eject),
    .wdata      (hp_wdata),
    .ej_valid_q (eject_valid),
    .ej_slot_q  (eject_slot)
  );

  always_comb begin
    case (hsel)
      HSEL_INS: hp_rdata = ins_q;
      HSEL_REM: hp_rdata = rem_q;
      default:  hp_rdata = '0;
    endcase
  end

  assign gpe_pending = stat_q[HP_BIT] & en_q[HP_BIT];

  AST_PEND_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_take && en_q[HP_BIT] && !(gpe_wr_en && gpe_addr == GPE_AW'(2))) |=>
      gpe_pending); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (!eject_valid && !gpe_pending && hp_rdata == '0)); // R11

endmodule

// File: tb/gpe_hotplug_regs_test.sv
`timescale 1ns/1ps
module gpe_hotplug_regs_test;

  logic        clk;
  logic        rst_n;
  logic        gpe_wr_en;
  logic [2:0]  gpe_addr;
  logic [7:0]  gpe_wdata;
  logic [7:0]  gpe_rdata;
  logic        hp_wr_en;
  logic [3:0]  hp_addr;
  logic [31:0] hp_wdata;
  logic [31:0] hp_rdata;
  logic        ev_valid;
  logic        ev_hotadded;
  logic        ev_insert;
  logic [4:0]  ev_slot;
  logic        gpe_pending;
  logic        eject_valid;
  logic [4:0]  eject_slot;

  gpe_hotplug_regs uut (
    .clk(clk), .rst_n(rst_n),
    .gpe_wr_en(gpe_wr_en), .gpe_addr(gpe_addr), .gpe_wdata(gpe_wdata), .gpe_rdata(gpe_rdata),
    .hp_wr_en(hp_wr_en), .hp_addr(hp_addr), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
    .ev_valid(ev_valid), .ev_hotadded(ev_hotadded), .ev_insert(ev_insert), .ev_slot(ev_slot),
    .gpe_pending(gpe_pending), .eject_valid(eject_valid), .eject_slot(eject_slot)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    comparing = 0;
  string cur_req = "R11";

  // behavioural reference state
  logic [15:0] m_stat, m_en;
  logic [31:0] m_ins, m_rem;
  logic        m_ejv;
  int          m_ejs;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_ins = 0; m_rem = 0; m_ejv = 0; m_ejs = 0;
    end else begin
      m_ejv = 0;
      if (gpe_wr_en) begin
        if (gpe_addr == 0) m_stat = m_stat & ~{8'h00, gpe_wdata};
        if (gpe_addr == 1) m_stat = m_stat & ~{gpe_wdata, 8'h00};
        if (gpe_addr == 2) m_en[7:0]  = gpe_wdata;
        if (gpe_addr == 3) m_en[15:8] = gpe_wdata;
      end
      if (hp_wr_en) begin
        if (hp_addr == 0) m_ins = hp_wdata;
        if (hp_addr == 4) m_rem = hp_wdata;
        if (hp_addr == 8 && hp_wdata != 0) begin
          bit found;
          found = 0;
          m_ejv = 1;
          for (int i = 0; i < 32; i++) begin
            if (hp_wdata[i] && !found) begin found = 1; m_ejs = i; end
          end
        end
      end
      if (ev_valid && ev_hotadded) begin
        m_ins = 0; m_rem = 0;
        if (ev_insert) m_ins[ev_slot] = 1'b1;
        else           m_rem[ev_slot] = 1'b1;
        m_stat[1] = 1'b1;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_g();
    case (gpe_addr)
      3'd0: return {24'h0, m_stat[7:0]};
      3'd1: return {24'h0, m_stat[15:8]};
      3'd2: return {24'h0, m_en[7:0]};
      3'd3: return {24'h0, m_en[15:8]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_h();
    if (hp_addr == 0) return m_ins;
    if (hp_addr == 4) return m_rem;
    return 32'h0;
  endfunction

  task automatic tick();
    @(negedge clk);
    if (comparing) begin
      chk(cur_req, "gpe_rdata", {24'h0, gpe_rdata}, exp_g());
      chk(cur_req, "hp_rdata", hp_rdata, exp_h());
      chk("R5", "gpe_pending", {31'h0, gpe_pending}, {31'h0, m_stat[1] & m_en[1]});
      chk("R9", "eject_valid", {31'h0, eject_valid}, {31'h0, m_ejv});
      if (m_ejv) chk("R9", "eject_slot", {27'h0, eject_slot}, 32'(m_ejs));
    end
  endtask

  task automatic gw(input logic [2:0] a, input logic [7:0] d);
    gpe_wr_en = 1; gpe_addr = a; gpe_wdata = d;
    tick();
    gpe_wr_en = 0;
  endtask

  task automatic hw(input logic [3:0] a, input logic [31:0] d);
    hp_wr_en = 1; hp_addr = a; hp_wdata = d;
    tick();
    hp_wr_en = 0;
  endtask

  task automatic ev(input logic hot, input logic ins, input logic [4:0] s);
    ev_valid = 1; ev_hotadded = hot; ev_insert = ins; ev_slot = s;
    tick();
    ev_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; gpe_wr_en = 0; gpe_addr = 0; gpe_wdata = 0;
    hp_wr_en = 0; hp_addr = 0; hp_wdata = 0;
    ev_valid = 0; ev_hotadded = 0; ev_insert = 0; ev_slot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    comparing = 1;

    // R11: state after reset
    cur_req = "R11";
    for (int a = 0; a < 4; a++) begin gpe_addr = 3'(a); hp_addr = 4'(a * 4); tick(); end
    chk("R11", "gpe_pending", {31'h0, gpe_pending}, 32'h0);

    // R1 / R3: enable bytes written and read back separately
    cur_req = "R3";
    gw(3'd2, 8'hA5); gw(3'd3, 8'h3C);
    cur_req = "R1";
    gpe_addr = 3'd2; tick(); chk("R1", "enable low", {24'h0, gpe_rdata}, 32'hA5);
    gpe_addr = 3'd3; tick(); chk("R1", "enable high", {24'h0, gpe_rdata}, 32'h3C);
    gpe_addr = 3'd0; tick();

    // R7 / R5: insertion event, pending follows enable bit 1
    cur_req = "R7";
    ev(1'b1, 1'b1, 5'd5);
    hp_addr = 4'h0; tick(); chk("R7", "inserted map", hp_rdata, 32'h0000_0020);
    cur_req = "R5";
    chk("R5", "pending with enable bit 1 clear", {31'h0, gpe_pending}, 32'h0);
    gw(3'd2, 8'h02); tick();
    chk("R5", "pending with both bits set", {31'h0, gpe_pending}, 32'h1);

    // R2: write-one-to-clear per byte
    cur_req = "R2";
    gw(3'd0, 8'h01); gw(3'd1, 8'hFF);
    gpe_addr = 3'd0; tick(); chk("R2", "status low kept", {24'h0, gpe_rdata}, 32'h02);
    gw(3'd0, 8'h02); gpe_addr = 3'd0; tick();
    chk("R2", "status cleared", {24'h0, gpe_rdata}, 32'h00);

    // R4: unknown offsets
    cur_req = "R4";
    gw(3'd4, 8'hFF); gw(3'd6, 8'hFF); gw(3'd7, 8'h55);
    gpe_addr = 3'd5; tick(); gpe_addr = 3'd2; tick();
    chk("R4", "enable untouched", {24'h0, gpe_rdata}, 32'h02);

    // R6: software access to bitmaps
    cur_req = "R6";
    hw(4'h0, 32'hDEAD_BEEF); hw(4'h4, 32'h1234_5678); hw(4'hC, 32'hFFFF_FFFF); hw(4'h2, 32'h1);
    hp_addr = 4'h0; tick(); chk("R6", "inserted map", hp_rdata, 32'hDEAD_BEEF);
    hp_addr = 4'h4; tick(); chk("R6", "removed map", hp_rdata, 32'h1234_5678);
    hp_addr = 4'h8; tick(); hp_addr = 4'hC; tick();

    // R7: removal events at both ends, event beats software write
    cur_req = "R7";
    ev(1'b1, 1'b0, 5'd31); hp_addr = 4'h4; tick();
    chk("R7", "removed map slot 31", hp_rdata, 32'h8000_0000);
    ev(1'b1, 1'b0, 5'd0); hp_addr = 4'h0; tick();
    hp_wr_en = 1; hp_addr = 4'h4; hp_wdata = 32'hFFFF_0000;
    gpe_wr_en = 1; gpe_addr = 3'd0; gpe_wdata = 8'h02;
    ev_valid = 1; ev_hotadded = 1; ev_insert = 1; ev_slot = 5'd17;
    tick();
    hp_wr_en = 0; gpe_wr_en = 0; ev_valid = 0;
    tick(); chk("R7", "removed map after collision", hp_rdata, 32'h0);

    // R8: event for a card present at boot
    cur_req = "R8";
    ev(1'b0, 1'b0, 5'd3); hp_addr = 4'h0; tick();
    chk("R8", "inserted map unchanged", hp_rdata, 32'h0002_0000);

    // R9 / R10: eject
    cur_req = "R9";
    hw(4'h8, 32'h0000_0028);
    chk("R9", "eject slot", {27'h0, eject_slot}, 32'd3);
    hw(4'h8, 32'h8000_0000);
    hw(4'h8, 32'hFFFF_FFFF);
    chk("R9", "eject slot all ones", {27'h0, eject_slot}, 32'd0);
    tick();
    cur_req = "R10";
    hw(4'h8, 32'h0);
    chk("R10", "no eject pulse", {31'h0, eject_valid}, 32'h0);

    // mixed random traffic, model compared each cycle
    cur_req = "R7";
    for (int k = 0; k < 600; k++) begin
      gpe_wr_en   = ($urandom % 3) == 0;
      gpe_addr    = 3'($urandom);
      gpe_wdata   = 8'($urandom);
      hp_wr_en    = ($urandom % 3) == 0;
      case ($urandom % 5)
        0: hp_addr = 4'h0; 1: hp_addr = 4'h4; 2: hp_addr = 4'h8;
        3: hp_addr = 4'hC; default: hp_addr = 4'h1;
      endcase
      hp_wdata    = (($urandom % 4) == 0) ? 32'h0 : ($urandom << ($urandom % 32));
      ev_valid    = ($urandom % 4) == 0;
      ev_hotadded = ($urandom % 4) != 0;
      ev_insert   = 1'($urandom);
      ev_slot     = 5'($urandom);
      tick();
    end
    gpe_wr_en = 0; hp_wr_en = 0; ev_valid = 0;
    tick(); tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule